// File: doc/BRIEF.md
# Three-Level Strap Mode Decoder

This block captures the board strap inputs of a clock generator once, at power-up, and turns them into the operating mode that the rest of the generator follows. The mode strap is a three-level pin. An analog front end outside this block has already classified it into a two-bit level code. Two further binary straps pick the processor clock frequency in the normal modes and pick the sub-mode when the mode strap sits at the middle level.

The straps are captured on the first clock edge at which the active-low power-good strobe is seen low. From then on they are frozen until reset. The decoded result can take one of these forms:
- a processor frequency code, in the two normal modes;
- a choice between passing an external 66 MHz input to the buffered outputs and using the internal 66/33 MHz clocks;
- a flag that places every output in high impedance;
- a test-mode flag;
- a reserved-mode flag.

In test mode the block clock is the external test clock. A single shared counter then produces the divide-by-2, -4 and -8 outputs, all starting in phase. The latched straps are also available read-only for a register bank.

Top module: `strap_mode_decoder`

## Requirements
- R1: The straps are latched on the first rising clock edge at which `pg_n` is low. After that edge, `locked` stays 1, and neither later `pg_n` activity nor changes on the strap inputs alter the latched values until reset.
- R2: In a normal mode, `cpu_fsel` equals the latched `fsel_pin` value. The codes are 0 = 66 MHz, 1 = 100 MHz, 2 = 200 MHz and 3 = 133 MHz. In every other state `cpu_fsel` is 0.
- R3: `buf66_sel` is 1 exactly when the latched level code is 2'b10 (high). With a latched level of 2'b00 (low), the internal clocks are used and `buf66_sel` is 0.
- R4: A latched mid level with `fsel_pin` = 2'b00 raises `all_hiz` and no other mode output.
- R5: A latched mid level with `fsel_pin` = 2'b01 raises `test_mode`. In test mode the reference output passes the test clock straight through.
- R6: In test mode, `tst_div[i]` is a divide-by-2^(i+1) of the clock. The shared counter is 0 on the first cycle of test mode and steps by one on each following clock. Outside test mode, `tst_div` is 0.
- R7: A latched mid level with `fsel_pin` = 2'b10 or 2'b11 raises `rsvd_mode`. In that case `cpu_fsel`, `buf66_sel`, `all_hiz`, `test_mode` and `tst_div` are all 0.
- R8: The level code 2'b11 is decoded the same way as mid (2'b01).
- R9: Before the straps are latched, every mode output is 0. `strap_rb` always reads {latched level, latched fsel} and is 0 after reset.
- R10: At most one of `all_hiz`, `test_mode` and `rsvd_mode` is 1, and none of them is 1 while a normal mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the test clock in test mode |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pg_n | input | 1 | Active-low power-good strobe qualifying the strap capture |
| lvl_code | input | 2 | Classified three-level strap: 00 low, 01 mid, 10 high, 11 mid |
| fsel_pin | input | 2 | Binary frequency/sub-mode straps |
| locked | output | 1 | Straps have been captured |
| cpu_fsel | output | 2 | Processor frequency code |
| buf66_sel | output | 1 | Buffer external 66 MHz input instead of internal clocks |
| all_hiz | output | 1 | All clock outputs in high impedance |
| test_mode | output | 1 | Test mode; reference output passes the test clock |
| rsvd_mode | output | 1 | Reserved strap combination, outputs held low |
| tst_div | output | 3 | Test divider outputs, bit i = clk / 2^(i+1) |
| strap_rb | output | 4 | Read-only latched straps {level, fsel} |

## Verification
On every cycle, the assertions check the following:
- the latched straps are frozen once captured;
- the mode flags are mutually exclusive;
- reserved and high-impedance modes keep the other outputs quiet;
- the divider counter either steps by one or sits at zero.

Only the bench scenarios can show the rest:
- that capture happens on the first strobe edge, not a later one;
- that each strap combination decodes to the intended mode, including the 2'b11 alias;
- that the divided clocks start in phase right after test mode begins.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int LVL_W = 2;
  localparam int SEL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_ALT  = 2'b11
  } lvl_e;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_INT66,
    MD_BUF66,
    MD_HIZ,
    MD_TEST,
    MD_RSVD
  } mode_e;

  localparam logic [SEL_W-1:0] SUB_HIZ  = 2'b00;
  localparam logic [SEL_W-1:0] SUB_TEST = 2'b01;
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_n,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic             locked,
  output logic [LVL_W-1:0] lvl_q,
  output logic [SEL_W-1:0] sel_q
);
  logic             locked_d;
  logic [LVL_W-1:0] lvl_d;
  logic [SEL_W-1:0] sel_d;
  logic             cap_en;

  // Capture only once: the first cycle the strobe is low
  assign cap_en = !locked && !pg_n;

  always_comb begin
    locked_d = locked;
    lvl_d    = lvl_q;
    sel_d    = sel_q;
    if (cap_en) begin
      locked_d = 1'b1;
      lvl_d    = lvl_in;
      sel_d    = sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      lvl_q  <= '0;
      sel_q  <= '0;
    end else begin
      locked <= locked_d;
      lvl_q  <= lvl_d;
      sel_q  <= sel_d;
    end
  end

  // R1: once captured, the straps never move
  assert_hold_after_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(lvl_q) && $stable(sel_q)));

  // R9: nothing is captured while the strobe stays high
  assert_no_capture_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && pg_n) |=> !locked);
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic [SEL_W-1:0] sel_q,
  output mode_e            mode,
  output logic [SEL_W-1:0] cpu_fsel,
  output logic             buf66_sel,
  output logic             all_hiz,
  output logic             test_mode,
  output logic             rsvd_mode
);
  logic is_mid;

  // Level code 2'b11 is an alias of mid
  assign is_mid = (lvl_q == LVL_MID) || (lvl_q == LVL_ALT);

  always_comb begin
    mode = MD_IDLE;
    if (locked) begin
      if (lvl_q == LVL_HIGH)      mode = MD_BUF66;
      else if (!is_mid)           mode = MD_INT66;
      else if (sel_q == SUB_HIZ)  mode = MD_HIZ;
      else if (sel_q == SUB_TEST) mode = MD_TEST;
      else                        mode = MD_RSVD;
    end
  end

  always_comb begin
    cpu_fsel  = '0;
    buf66_sel = 1'b0;
    all_hiz   = 1'b0;
    test_mode = 1'b0;
    rsvd_mode = 1'b0;
    unique case (mode)
      MD_INT66: cpu_fsel = sel_q;
      MD_BUF66: begin
        cpu_fsel  = sel_q;
        buf66_sel = 1'b1;
      end
      MD_HIZ:   all_hiz   = 1'b1;
      MD_TEST:  test_mode = 1'b1;
      MD_RSVD:  rsvd_mode = 1'b1;
      default:  ;
    endcase
  end

  // R10: the special-mode flags are exclusive
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({all_hiz, test_mode, rsvd_mode, buf66_sel}));

  // R7: reserved mode keeps every other output low
  assert_rsvd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_mode |-> (cpu_fsel == '0 && !buf66_sel && !all_hiz && !test_mode));

  // R4: high impedance mode has no frequency code
  assert_hiz_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    all_hiz |-> (cpu_fsel == '0 && !test_mode));

  // R9: no mode before the straps are latched
  assert_idle_before_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !(all_hiz || test_mode || rsvd_mode || buf66_sel));
endmodule

// File: rtl/test_divider.sv
module test_divider #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] div_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_d;

  // Held at zero outside test mode, so all taps start aligned
  always_comb begin
    if (en) cnt_d = cnt + ONE;
    else    cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_tap
    assign div_out[i] = cnt[i] & en;
  end

  // R6: counter steps by one while enabled
  assert_div_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (cnt == $past(cnt) + ONE));

  // R6: counter is cleared when not enabled
  assert_div_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/strap_mode_decoder.sv
module strap_mode_decoder
  import strap_pkg::*;
#(
  parameter int DIV_TAPS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pg_n,
  input  logic [1:0]             lvl_code,
  input  logic [1:0]             fsel_pin,
  output logic                   locked,
  output logic [1:0]             cpu_fsel,
  output logic                   buf66_sel,
  output logic                   all_hiz,
  output logic                   test_mode,
  output logic                   rsvd_mode,
  output logic [DIV_TAPS-1:0]    tst_div,
  output logic [LVL_W+SEL_W-1:0] strap_rb
);
  logic [LVL_W-1:0] lvl_q;
  logic [SEL_W-1:0] sel_q;
  mode_e            mode;

  strap_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .pg_n   (pg_n),
    .lvl_in (lvl_code),
    .sel_in (fsel_pin),
    .locked (locked),
    .lvl_q  (lvl_q),
    .sel_q  (sel_q)
  );

  strap_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (locked),
    .lvl_q     (lvl_q),
    .sel_q     (sel_q),
    .mode      (mode),
    .cpu_fsel  (cpu_fsel),
    .buf66_sel (buf66_sel),
    .all_hiz   (all_hiz),
    .test_mode (test_mode),
    .rsvd_mode (rsvd_mode)
  );

  test_divider #(.CNT_W(DIV_TAPS)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mode == MD_TEST),
    .div_out (tst_div)
  );

  assign strap_rb = {lvl_q, sel_q};

  // R5: the divider only runs alongside the test flag
  assert_div_only_in_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (tst_div == '0));
endmodule

// File: tb/strap_mode_decoder_bench.sv
module strap_mode_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_n = 1'b1;
  logic [1:0] lvl_code = 2'b00;
  logic [1:0] fsel_pin = 2'b00;
  logic locked, buf66_sel, all_hiz, test_mode, rsvd_mode;
  logic [1:0] cpu_fsel;
  logic [TAPS-1:0] tst_div;
  logic [3:0] strap_rb;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  strap_mode_decoder #(.DIV_TAPS(TAPS)) u_strap_mode_decoder (
    .clk(clk), .rst_n(rst_n), .pg_n(pg_n), .lvl_code(lvl_code),
    .fsel_pin(fsel_pin), .locked(locked), .cpu_fsel(cpu_fsel),
    .buf66_sel(buf66_sel), .all_hiz(all_hiz), .test_mode(test_mode),
    .rsvd_mode(rsvd_mode), .tst_div(tst_div), .strap_rb(strap_rb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_locked, m_lvl, m_sel, m_cnt;
  bit m_was_test;

  function automatic bit m_mid();
    return (m_lvl == 1) || (m_lvl == 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locked = 0; m_lvl = 0; m_sel = 0; m_cnt = 0;
    end else begin
      m_was_test = (m_locked != 0) && m_mid() && (m_sel == 1);
      if (m_locked == 0 && pg_n == 1'b0) begin
        m_locked = 1; m_lvl = int'(lvl_code); m_sel = int'(fsel_pin);
      end
      m_cnt = m_was_test ? (m_cnt + 1) % (1 << TAPS) : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit lk, norm, e_test;
      int e_div;
      lk = (m_locked != 0);
      norm = lk && !m_mid();
      e_test = lk && m_mid() && m_sel == 1;
      e_div = e_test ? m_cnt : 0;
      chk("R1 locked", int'(locked), int'(lk));
      chk("R2 cpu_fsel", int'(cpu_fsel), norm ? m_sel : 0);
      chk("R3 buf66_sel", int'(buf66_sel), int'(lk && m_lvl == 2));
      chk("R4 all_hiz", int'(all_hiz), int'(lk && m_mid() && m_sel == 0));
      chk("R5 test_mode", int'(test_mode), int'(e_test));
      chk("R6 tst_div", int'(tst_div), e_div);
      chk("R7 rsvd_mode", int'(rsvd_mode), int'(lk && m_mid() && m_sel >= 2));
      chk("R9 strap_rb", int'(strap_rb), m_lvl * 4 + m_sel);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Scenario: strap, capture, then disturb pins and strobe (must be ignored, R1)
  task automatic run_case(input logic [1:0] lv, input logic [1:0] sl);
    rst_n = 1'b0; pg_n = 1'b1; lvl_code = lv; fsel_pin = sl;
    step(2);
    rst_n = 1'b1;
    step(3);           // R9: idle before capture
    pg_n = 1'b0;
    step(1);
    pg_n = 1'b1; lvl_code = ~lv; fsel_pin = ~sl;
    step(3);
    pg_n = 1'b0;
    step(2);
    pg_n = 1'b1;
    step(20);
  endtask

  initial begin
    step(1);
    rst_n = 1'b0;
    step(2);
    for (int l = 0; l < 4; l++) begin
      for (int s = 0; s < 4; s++) begin
        run_case(2'(l), 2'(s));   // l==3 exercises R8 alias
      end
    end
    // Test entry twice without strobe gap: R6 alignment after fresh reset
    run_case(2'b01, 2'b01);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule